// File: doc/BRIEF.md
# Dual Trigger Event Capture

This block watches two asynchronous trigger lines. Each line is brought into the clock domain through two flip-flops, and then compared with the last level the block accepted. A rise or a fall on either line sets a sticky pending flag for that line. The same event records the value of an external free-running time base in a stamp register. That time base is the one the video path uses to stamp frames, so a trigger can be matched to a frame.

Software reads a fixed 8-bit activity word. The word carries both the live levels and the pending flags. The live levels are useful when software polls the lines. The pending flags and the stamp are useful when software collects events. A one-cycle acknowledge strobe clears the pending flags and releases the stamp register for the next event. An interrupt request stays asserted while any pending flag is set.

Top module: `trig_capture`

## Requirements
- R1: The activity word uses a fixed layout. Bit 1 is the pending flag of trigger 1 (`trig_i[0]`) and bit 2 is the pending flag of trigger 2 (`trig_i[1]`). Bit 5 is the level of trigger 1 and bit 6 is the level of trigger 2. Bits 0, 3, 4 and 7 always read 0.
- R2: A change on `trig_i` appears in the level bits on the third rising clock edge after the change.
- R3: Both a rising and a falling change of a trigger set its pending flag on that same third edge.
- R4: A pending flag stays set until `ack_i` is high at a clock edge. At that edge it clears, unless R8 applies.
- R5: When an event sets a pending flag while no flag is already pending, `stamp_o` takes the value `tstamp_i` had just before that edge. The stamp then stays unchanged while any flag is pending.
- R6: If both triggers change in the same cycle, both pending flags are set together and share one stamp.
- R7: An event on the second trigger while the first trigger's flag is pending sets the second flag and leaves `stamp_o` unchanged.
- R8: If an event arrives at the same edge as `ack_i`, the old flags clear. The new event's flag is set and a new stamp is taken.
- R9: `irq_o` is high exactly when at least one pending flag is set.
- R10: After reset, the activity word, `stamp_o` and `irq_o` are all 0. The accepted levels start low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trig_i | input | 2 | Asynchronous trigger lines; bit 0 is trigger 1 |
| tstamp_i | input | TS_W | Shared free-running time base |
| ack_i | input | 1 | Acknowledge strobe; clears pending flags |
| activity_o | output | 8 | Level and pending status word |
| stamp_o | output | TS_W | Time of the first event since the last acknowledge |
| irq_o | output | 1 | High while any flag is pending |

## Verification
The bench builds the block with a 16-bit time base. The bench drives that time base from its own cycle counter, so every expected stamp is simply the cycle count at which the trigger was changed, plus two. With that width, the bench can compare the three-edge latency, the held stamp under a second event, and the acknowledge-versus-event race exactly.

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      trig_i,
  input  logic [TS_W-1:0] tstamp_i,
  input  logic            ack_i,
  output logic [7:0]      activity_o,
  output logic [TS_W-1:0] stamp_o,
  output logic            irq_o
);
  logic [1:0] meta_q, sync_q, lvl_q, pend_q;
  logic [TS_W-1:0] stamp_q;
  logic [1:0] chg;
  logic       take_stamp;

  assign chg        = sync_q ^ lvl_q;
  assign take_stamp = (|chg) && ((pend_q == 2'b00) || ack_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      meta_q  <= '0;
      sync_q  <= '0;
      lvl_q   <= '0;
      pend_q  <= '0;
      stamp_q <= '0;
    end else begin
      meta_q <= trig_i;
      sync_q <= meta_q;
      lvl_q  <= sync_q;
      pend_q <= (ack_i ? 2'b00 : pend_q) | chg;
      if (take_stamp) stamp_q <= tstamp_i;
    end
  end

  assign activity_o = {1'b0, lvl_q[1], lvl_q[0], 2'b00, pend_q[1], pend_q[0], 1'b0};
  assign stamp_o    = stamp_q;
  assign irq_o      = |pend_q;
endmodule

module trig_capture_chk #(
  parameter int TS_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ack_i,
  input logic [7:0]      activity_o,
  input logic [TS_W-1:0] stamp_o,
  input logic            irq_o
);
  p_unused_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (activity_o & 8'b1001_1001) == 8'h00);
  p_pend1_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (activity_o[1] && !ack_i) |=> activity_o[1]);
  p_pend2_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (activity_o[2] && !ack_i) |=> activity_o[2]);
  p_stamp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> $stable(stamp_o));
  p_irq_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (activity_o[1] || activity_o[2]));
endmodule

bind trig_capture trig_capture_chk #(.TS_W(TS_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i),
  .activity_o(activity_o), .stamp_o(stamp_o), .irq_o(irq_o)
);

// File: tb/trig_capture_tb_top.sv
module trig_capture_tb_top;
  localparam int TS_W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] trig = 2'b00;
  logic ack = 1'b0;
  logic [TS_W-1:0] tbase = '0;
  logic [7:0] act;
  logic [TS_W-1:0] stamp;
  logic irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) tbase <= tbase + 1'b1;

  trig_capture #(.TS_W(TS_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .tstamp_i(tbase),
    .ack_i(ack), .activity_o(act), .stamp_o(stamp), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(logic [1:0] v, output logic [TS_W-1:0] t0);
    @(negedge clk);
    trig = v;
    t0 = tbase;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 act", act, 8'h00);
    chk("R10 stamp", stamp, 0);
    chk("R10 irq", irq, 0);
  endtask

  task automatic t_rise_and_hold();
    logic [TS_W-1:0] t0;
    @(negedge clk);
    trig = 2'b01;
    t0 = tbase;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 latency", act, 8'h00);
    @(negedge clk);
    chk("R1 R3 rise act", act, 8'h22);
    chk("R5 stamp", stamp, t0 + 2);
    chk("R9 irq set", irq, 1);
    repeat (5) @(negedge clk);
    chk("R4 sticky", act, 8'h22);
    chk("R5 held", stamp, t0 + 2);
  endtask

  task automatic t_second_event();
    logic [TS_W-1:0] t0, told;
    told = stamp;
    drive(2'b11, t0);
    chk("R7 act", act, 8'h66);
    chk("R7 stamp", stamp, told);
    do_ack();
    chk("R4 ack clears", act, 8'h60);
    chk("R9 irq clear", irq, 0);
  endtask

  task automatic t_fall();
    logic [TS_W-1:0] t0;
    drive(2'b10, t0);
    chk("R3 fall act", act, 8'h42);
    chk("R3 fall stamp", stamp, t0 + 2);
    do_ack();
  endtask

  task automatic t_both();
    logic [TS_W-1:0] t0;
    drive(2'b01, t0);
    chk("R6 act", act, 8'h26);
    chk("R6 stamp", stamp, t0 + 2);
    do_ack();
  endtask

  task automatic t_ack_race();
    logic [TS_W-1:0] t0, t1;
    drive(2'b00, t0);
    chk("R8 pre act", act, 8'h02);
    @(negedge clk);
    trig = 2'b10;
    t1 = tbase;
    repeat (2) @(posedge clk);
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R8 act", act, 8'h44);
    chk("R8 stamp", stamp, t1 + 2);
    do_ack();
    chk("R8 cleared", act, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rise_and_hold();
    t_second_event();
    t_fall();
    t_both();
    t_ack_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++;
    bad++;
    $display("FAIL watchdog got=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule